// File: doc/BRIEF.md
# Floating-Point Reciprocal Estimate Unit

This block produces a coarse, bit-exact approximation of 1/x for one floating-point operand per cycle. It looks up 8 fraction bits in a 256-entry table and builds the result exponent by reflecting the input exponent around 2045. In double mode it works directly on a 64-bit binary64 operand. In single mode it reads a binary32 operand from the low 32 bits. It widens that operand exactly to binary64, forms the estimate, and rounds the result back to binary32 with round-to-nearest-even. The single result is returned in the low 32 bits and the upper half is zero.

The unit is meant to seed an iterative divider or reciprocal refinement. A caller presents an operand with `in_valid` and reads the estimate one clock later, when `out_valid` is high. The result register holds its last value until the next valid operand.

For double results whose exponent field would come out as 0 or all ones, the core re-encodes the result as a subnormal. A computed exponent of 0 shifts the fraction right by one and sets fraction bit 51. A computed exponent of all ones sets the exponent field to 0, shifts the fraction right by two and sets fraction bit 50. With the exponent range reachable from legal inputs, this re-encoding is never exercised at the ports.

Top module: `recip_est_top`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. A synchronous reset clears `out_valid` to 0 and `out_res` to all zeros.
- R2: `out_res` loads only on a clock edge where `in_valid` is 1. Otherwise it keeps its previous value.
- R3: In double mode (`in_dp`=1), a NaN input (exponent field 0x7FF, fraction non-zero) returns the input with fraction bit 51 set to 1.
- R4: In double mode, a non-NaN input with exponent field 2045 or larger (infinity included) returns a zero with the input's sign.
- R5: A zero input of either sign returns an infinity of the same sign, in both modes. The double infinity is 0x7FF0000000000000 with the sign in bit 63. The single infinity is 0x7F800000 with the sign in bit 31.
- R6: For a normal double input with exponent e below 2045, the result has the input's sign and exponent (2045 - e) mod 2048. The fraction is T[f[51:44]] placed at bits 51:44, with zeros below. Each table entry is T[i] = low 8 bits of ((0x80000 / (2*(i|0x100)+1)) + 1) >> 1, using integer division.
- R7: For a double subnormal input with fraction bit 51 clear, the exponent is taken as -1 and the fraction is shifted left by 2 before indexing. If bit 51 is set, the exponent stays 0 and the fraction is shifted left by 1.
- R8: In single mode (`in_dp`=0), bits 63:32 of `in_op` are ignored and `out_res[63:32]` is 0. For example, 0x41200000 maps to 0x3DCC8000 and 0xC1200000 maps to 0xBDCC8000.
- R9: In single mode, subnormal inputs are normalised exactly before the estimate. Results beyond the binary32 range saturate to a signed infinity. For example, 0x00FFF000 maps to 0x7E000000, 0x007FF000 maps to 0x7E800000, and 0x001FFFFF maps to 0x7F800000.
- R10: In single mode, results below the binary32 normal range are returned as binary32 subnormals, rounded to nearest even. For example, 0x7F000000 maps to 0x003FE000.
- R11: In single mode, a NaN input returns the binary32 NaN with fraction bit 22 set and its other payload bits kept. A single infinity returns a signed zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand valid this cycle |
| in_dp | input | 1 | 1 = binary64 operand, 0 = binary32 operand in bits 31:0 |
| in_op | input | 64 | Operand |
| out_valid | output | 1 | Result valid |
| out_res | output | 64 | Estimate; binary32 results in bits 31:0 |

## Verification
The hardest results to reach are the binary32 subnormal outputs. They appear only when the reflected exponent falls below the binary32 normal range. That happens only for single inputs whose exponent field is 253 or 254. The stimulus therefore drives large-magnitude singles of both signs, including the largest finite value, to reach every such output. Double subnormal inputs with fraction bit 51 set and clear are applied directly, to cover both normalisation shifts. Single inputs with non-zero upper bits show that those bits are ignored.

// File: rtl/recip_est_pkg.sv
package recip_est_pkg;

    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_W      = 1 + DP_EXP_W + DP_FRAC_W;
    localparam int SP_W      = 1 + SP_EXP_W + SP_FRAC_W;
    localparam int IDX_W     = 8;
    localparam int TBL_DEPTH = 1 << IDX_W;
    localparam int EXP_PIVOT = 2045;
    localparam int EXP_SHIFT = 896;   // binary64 bias minus binary32 bias
    localparam int FRAC_GAP  = DP_FRAC_W - SP_FRAC_W;

    typedef struct packed {
        logic                 sign;
        logic [DP_EXP_W-1:0]  exp;
        logic [DP_FRAC_W-1:0] frac;
    } dp_t;

    typedef struct packed {
        logic                 sign;
        logic [SP_EXP_W-1:0]  exp;
        logic [SP_FRAC_W-1:0] frac;
    } sp_t;

    // One table entry: rounded 1/(1.idx + half step), fraction bits only
    function automatic logic [IDX_W-1:0] tbl_entry(input logic [IDX_W-1:0] idx);
        logic [19:0] den;
        logic [19:0] quo;
        den = 20'({1'b1, idx, 1'b1});
        quo = 20'h80000 / den;
        quo = (quo + 20'd1) >> 1;
        return quo[IDX_W-1:0];
    endfunction

endpackage

// File: rtl/recip_sp_widen.sv
module recip_sp_widen
    import recip_est_pkg::*;
(
    input  sp_t sp_in,
    output dp_t dp_out
);
    logic [4:0]           lead;
    logic [DP_FRAC_W:0]   norm;

    always_comb begin
        lead = '0;
        for (int i = 0; i < SP_FRAC_W; i++) begin
            if (sp_in.frac[i]) lead = 5'(i);
        end
        norm = {{(DP_FRAC_W+1-SP_FRAC_W){1'b0}}, sp_in.frac} << (6'(DP_FRAC_W) - {1'b0, lead});

        dp_out.sign = sp_in.sign;
        if (sp_in.exp == '1) begin
            dp_out.exp  = '1;
            dp_out.frac = {sp_in.frac, {FRAC_GAP{1'b0}}};
        end else if (sp_in.exp == '0) begin
            if (sp_in.frac == '0) begin
                dp_out.exp  = '0;
                dp_out.frac = '0;
            end else begin
                dp_out.exp  = DP_EXP_W'(EXP_SHIFT - SP_FRAC_W - 1 + 2) + DP_EXP_W'(lead);
                dp_out.frac = norm[DP_FRAC_W-1:0];
            end
        end else begin
            dp_out.exp  = DP_EXP_W'(EXP_SHIFT) + DP_EXP_W'(sp_in.exp);
            dp_out.frac = {sp_in.frac, {FRAC_GAP{1'b0}}};
        end
    end
endmodule

// File: rtl/recip_dp_core.sv
module recip_dp_core
    import recip_est_pkg::*;
(
    input  dp_t op,
    output dp_t res
);
    logic [IDX_W-1:0] rom [TBL_DEPTH];

    for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_rom
        assign rom[g] = tbl_entry(IDX_W'(g));
    end

    logic [DP_EXP_W:0]    e_wide;
    logic [DP_EXP_W:0]    e_diff;
    logic [DP_FRAC_W-1:0] f_norm;
    logic [DP_EXP_W-1:0]  r_exp;
    logic [DP_FRAC_W-1:0] r_frac;

    always_comb begin
        e_wide = {1'b0, op.exp};
        f_norm = op.frac;
        if (op.exp == '0) begin
            if (!op.frac[DP_FRAC_W-1]) begin
                e_wide = '1;
                f_norm = op.frac << 2;
            end else begin
                f_norm = op.frac << 1;
            end
        end
        e_diff = (DP_EXP_W+1)'(EXP_PIVOT) - e_wide;
        r_exp  = e_diff[DP_EXP_W-1:0];
        r_frac = {rom[f_norm[DP_FRAC_W-1 -: IDX_W]], {(DP_FRAC_W-IDX_W){1'b0}}};
        if (r_exp == '0) begin
            r_frac = (r_frac >> 1) | (DP_FRAC_W'(1) << (DP_FRAC_W-1));
        end else if (r_exp == '1) begin
            r_exp  = '0;
            r_frac = (r_frac >> 2) | (DP_FRAC_W'(1) << (DP_FRAC_W-2));
        end

        res.sign = op.sign;
        if ({1'b0, op.exp} >= (DP_EXP_W+1)'(EXP_PIVOT)) begin
            if (op.exp == '1 && op.frac != '0) begin
                res.exp  = op.exp;
                res.frac = op.frac | (DP_FRAC_W'(1) << (DP_FRAC_W-1));
            end else begin
                res.exp  = '0;
                res.frac = '0;
            end
        end else if (op.exp == '0 && op.frac == '0) begin
            res.exp  = '1;
            res.frac = '0;
        end else begin
            res.exp  = r_exp;
            res.frac = r_frac;
        end
    end
endmodule

// File: rtl/recip_dp_narrow.sv
module recip_dp_narrow
    import recip_est_pkg::*;
(
    input  dp_t dp_in,
    output sp_t sp_out
);
    localparam int WIDE_W = DP_FRAC_W + 1 + 32;

    logic signed [DP_EXP_W+1:0] se;
    logic signed [DP_EXP_W+1:0] sh;
    logic [SP_W-2:0]            nsum;
    logic [SP_W-2:0]            dsum;
    logic [WIDE_W-1:0]          wide;
    logic                       n_rnd;
    logic                       d_rnd;
    logic [SP_FRAC_W-1:0]       d_frac;

    always_comb begin
        se     = $signed({2'b00, dp_in.exp}) - (DP_EXP_W+2)'(EXP_SHIFT);
        sh     = (DP_EXP_W+2)'(1) - se;
        // normal range: guard at bit FRAC_GAP-1, sticky below
        n_rnd  = dp_in.frac[FRAC_GAP-1] &
                 ((|dp_in.frac[FRAC_GAP-2:0]) | dp_in.frac[FRAC_GAP]);
        nsum   = {se[SP_EXP_W-1:0], dp_in.frac[DP_FRAC_W-1:FRAC_GAP]} + (SP_W-1)'(n_rnd);
        // subnormal range
        wide   = {1'b1, dp_in.frac, 32'b0} >> sh[4:0];
        d_frac = wide[WIDE_W-2 -: SP_FRAC_W];
        d_rnd  = wide[WIDE_W-2-SP_FRAC_W] &
                 ((|wide[WIDE_W-3-SP_FRAC_W:0]) | d_frac[0]);
        dsum   = (SP_W-1)'(d_frac) + (SP_W-1)'(d_rnd);

        sp_out.sign = dp_in.sign;
        if (dp_in.exp == '1) begin
            sp_out.exp  = '1;
            sp_out.frac = (dp_in.frac != '0) ? dp_in.frac[DP_FRAC_W-1:FRAC_GAP] : '0;
        end else if (dp_in.exp == '0) begin
            sp_out.exp  = '0;
            sp_out.frac = '0;
        end else if (se >= (DP_EXP_W+2)'(255)) begin
            sp_out.exp  = '1;
            sp_out.frac = '0;
        end else if (se >= (DP_EXP_W+2)'(1)) begin
            {sp_out.exp, sp_out.frac} = nsum;
        end else if (sh > (DP_EXP_W+2)'(25)) begin
            sp_out.exp  = '0;
            sp_out.frac = '0;
        end else begin
            {sp_out.exp, sp_out.frac} = dsum;
        end
    end
endmodule

// File: rtl/recip_est_top.sv
module recip_est_top
    import recip_est_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            in_dp,
    input  logic [DP_W-1:0] in_op,
    output logic            out_valid,
    output logic [DP_W-1:0] out_res
);
    dp_t widened;
    dp_t core_in;
    dp_t core_out;
    sp_t narrowed;
    logic [DP_W-1:0] nxt_res;

    recip_sp_widen u_widen (
        .sp_in  (sp_t'(in_op[SP_W-1:0])),
        .dp_out (widened)
    );

    assign core_in = in_dp ? dp_t'(in_op) : widened;

    recip_dp_core u_core (
        .op  (core_in),
        .res (core_out)
    );

    recip_dp_narrow u_narrow (
        .dp_in  (core_out),
        .sp_out (narrowed)
    );

    assign nxt_res = in_dp ? DP_W'(core_out) : {{(DP_W-SP_W){1'b0}}, narrowed};

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_res   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_res <= nxt_res;
        end
    end

    assert_valid_follow_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid == 1'b0 || $past(in_valid) || $past(rst))
        else $error("out_valid without prior in_valid");

    assert_valid_rise_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_res));

    assert_nan_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_dp && in_op[62:52] == 11'h7FF && in_op[51:0] != '0)
        |=> out_res == ($past(in_op) | 64'h0008_0000_0000_0000));

    assert_zero_inf_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_dp && in_op[62:0] == '0)
        |=> out_res == {$past(in_op[63]), 11'h7FF, 52'b0});

    assert_single_upper_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_dp) |=> out_res[63:32] == '0);

endmodule

// File: tb/tb_recip_est_top.sv
module tb_recip_est_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 28;

    typedef struct packed {
        logic        dp;
        logic [63:0] op;
        logic [63:0] exp;
        logic [31:0] tag;
    } vec_t;

    localparam vec_t VECS [0:NV-1] = '{
        '{1'b1, 64'h3FF0000000000000, 64'h3FEFF00000000000, "R6"},
        '{1'b1, 64'h3FF8000000000000, 64'h3FE5500000000000, "R6"},
        '{1'b1, 64'hC000000000000000, 64'hBFDFF00000000000, "R6"},
        '{1'b1, 64'h7FC0000000000000, 64'h001FF00000000000, "R6"},
        '{1'b1, 64'h0000000000000000, 64'h7FF0000000000000, "R5"},
        '{1'b1, 64'h8000000000000000, 64'hFFF0000000000000, "R5"},
        '{1'b1, 64'h7FF0000000000001, 64'h7FF8000000000001, "R3"},
        '{1'b1, 64'hFFF4000000000000, 64'hFFFC000000000000, "R3"},
        '{1'b1, 64'hFFF0000000000000, 64'h8000000000000000, "R4"},
        '{1'b1, 64'h7FD0000000000000, 64'h0000000000000000, "R4"},
        '{1'b1, 64'h0008000000000000, 64'h7FDFF00000000000, "R7"},
        '{1'b1, 64'h0004000000000000, 64'h7FEFF00000000000, "R7"},
        '{1'b1, 64'h8000000000000001, 64'hFFEFF00000000000, "R7"},
        '{1'b0, 64'h0000000000000000, 64'h000000007F800000, "R5"},
        '{1'b0, 64'h0000000080000000, 64'h00000000FF800000, "R5"},
        '{1'b0, 64'h0000000041200000, 64'h000000003DCC8000, "R8"},
        '{1'b0, 64'hDEADBEEFC1200000, 64'h00000000BDCC8000, "R8"},
        '{1'b0, 64'hFFFFFFFF3F800000, 64'h000000003F7F8000, "R8"},
        '{1'b0, 64'h0000000000FFF000, 64'h000000007E000000, "R9"},
        '{1'b0, 64'h00000000007FF000, 64'h000000007E800000, "R9"},
        '{1'b0, 64'h00000000001FFFFF, 64'h000000007F800000, "R9"},
        '{1'b0, 64'h0000000000000001, 64'h000000007F800000, "R9"},
        '{1'b0, 64'h000000007F000000, 64'h00000000003FE000, "R10"},
        '{1'b0, 64'h00000000FF000000, 64'h00000000803FE000, "R10"},
        '{1'b0, 64'h000000007F7FFFFF, 64'h0000000000200000, "R10"},
        '{1'b0, 64'h000000007E800000, 64'h00000000007FC000, "R10"},
        '{1'b0, 64'h000000007F800001, 64'h000000007FC00001, "R11"},
        '{1'b0, 64'h00000000FF800000, 64'h0000000080000000, "R11"}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_dp = 1'b0;
    logic [63:0] in_op = '0;
    logic        out_valid;
    logic [63:0] out_res;

    int checks = 0;
    int failures = 0;

    recip_est_top dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_dp     (in_dp),
        .in_op     (in_op),
        .out_valid (out_valid),
        .out_res   (out_res)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check64("R1 reset valid", {63'b0, out_valid}, 64'd0);
        check64("R1 reset result", out_res, 64'd0);
        rst = 1'b0;

        // table walk, one operand at a time
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_dp    = VECS[i].dp;
            in_op    = VECS[i].op;
            @(negedge clk);
            in_valid = 1'b0;
            in_op    = 64'h3FF0000000000000;
            check64($sformatf("%s vec %0d valid", VECS[i].tag, i), {63'b0, out_valid}, 64'd1);
            check64($sformatf("%s vec %0d", VECS[i].tag, i), out_res, VECS[i].exp);
        end

        // R2: result holds while in_valid is low, inputs changing
        @(negedge clk);
        in_dp = 1'b1;
        in_op = 64'h0000000000000000;
        @(negedge clk);
        check64("R2 hold result", out_res, 64'h0000000080000000);
        check64("R1 idle valid low", {63'b0, out_valid}, 64'd0);

        // back-to-back operands, R1 and R6
        in_valid = 1'b1;
        in_dp    = 1'b1;
        in_op    = 64'h3FF0000000000000;
        @(negedge clk);
        check64("R1 b2b first valid", {63'b0, out_valid}, 64'd1);
        check64("R6 b2b first", out_res, 64'h3FEFF00000000000);
        in_dp = 1'b0;
        in_op = 64'h0000000041200000;
        @(negedge clk);
        in_valid = 1'b0;
        check64("R8 b2b second", out_res, 64'h000000003DCC8000);
        @(negedge clk);
        check64("R1 b2b drop valid", {63'b0, out_valid}, 64'd0);
        check64("R2 b2b hold", out_res, 64'h000000003DCC8000);

        // reset in mid run
        rst = 1'b1;
        @(negedge clk);
        check64("R1 mid reset result", out_res, 64'd0);
        check64("R1 mid reset valid", {63'b0, out_valid}, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule